// File: doc/BRIEF.md
# Multiplexed Display Row Scanner

This block produces the refresh scan for a monochrome dot matrix of 48 rows by 84 columns. The matrix image sits in a display memory arranged as six banks of 84 bytes. Each byte covers eight vertically stacked pixels of one column. The scanner walks the rows top to bottom, one row every ten display clocks, so a full frame takes 480 clocks. It drives a one-hot row select and an 84-bit column pattern for the row being shown.

For each row the scanner fetches the whole bank that holds it through a wide, one-cycle-latency read port. It slices out the bit for that row from every column byte. A global display mode is then applied: blank, normal, all pixels lit, or inverse video. The fetch for the next row is issued two clocks before the row boundary, so new column data and the new row select appear on the same clock edge. A single-clock frame marker flags the first clock of row 0.

A power-down input stops the scan and forces every output inactive. Reset leaves the block powered down and blank. When power-down is released, scanning always restarts at row 0.

Top module: `matrix_row_scanner`

## Requirements
- R1: While reset is held, and afterwards for as long as power-down stays high, row_sel_o and col_o are all zero and rd_en_o and frame_start_o are low.
- R2: row_sel_o is one-hot when scanning, with bit r high while row r is shown. Rows follow 0, 1, ..., 47 and then wrap to 0.
- R3: Each row is held for exactly 10 clocks, so consecutive frame_start_o pulses are 480 clocks apart.
- R4: frame_start_o is high for exactly the first clock of row 0 and low at all other times.
- R5: rd_en_o is high for one clock, in the 9th clock (slot 8) of each row. rd_bank_o then gives the bank of the next row, computed as next_row / 8. The data on rd_data_i is taken one clock later.
- R6: In normal mode, col_o[c] for row r equals bit (r mod 8) of byte c of the fetched bank. Byte c occupies rd_data_i[8c+7:8c], and bit 0 is the top row of the bank.
- R7: mode_i encodes {D,E}: 2'b00 blank (all columns 0), 2'b10 normal (pixel value), 2'b01 all on (all columns 1), 2'b11 inverse (inverted pixel value).
- R8: A change of mode_i takes effect only at the next row boundary. col_o stays fixed for the rest of the current row.
- R9: Raising pd_i (sampled at a rising edge) forces row_sel_o, col_o and frame_start_o to zero right after that edge. No reads are issued while power-down lasts.
- R10: After pd_i is first sampled low, the fetch for row 0 is issued in the next clock. Row 0 begins, with frame_start_o high, at the second rising edge after the one that sampled pd_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_i | input | 1 | Power-down request, active high |
| mode_i | input | 2 | Display mode {D,E} |
| rd_data_i | input | 672 | Bank read data, 84 bytes, byte c at bits 8c+7:8c |
| rd_en_o | output | 1 | Bank read request |
| rd_bank_o | output | 3 | Bank index of the read |
| row_sel_o | output | 48 | One-hot row select |
| col_o | output | 84 | Column pattern of the current row |
| frame_start_o | output | 1 | High on the first clock of row 0 |

## Verification
A wrong slot or row counter would show within one row period. The bank index on the read request would not match the next row, the row select would land on the wrong bit, or the frame marker spacing would drift away from 480 clocks. A wrong bit slice or mode decode would corrupt the column pattern on the very first row shown after the boundary, and it would differ from the arithmetic pattern the bench rebuilds. A mode or power-down flop that reacts on the wrong edge would show up as columns changing in the middle of a row, or as outputs still lit one clock after power-down.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK   = 2'b00,
    MODE_ALLON   = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_INVERSE = 2'b11
  } disp_mode_e;

  function automatic int bank_of(int row, int rows_per_bank);
    return row / rows_per_bank;
  endfunction

  function automatic int bit_of(int row, int rows_per_bank);
    return row % rows_per_bank;
  endfunction

  function automatic logic pixel_for_mode(disp_mode_e m, logic px);
    case (m)
      MODE_BLANK:   return 1'b0;
      MODE_ALLON:   return 1'b1;
      MODE_NORMAL:  return px;
      default:      return ~px;
    endcase
  endfunction

endpackage

// File: rtl/scan_timebase.sv
module scan_timebase
  import scan_pkg::*;
#(
  parameter int ROWS      = 48,
  parameter int ROW_CLKS  = 10,
  parameter int BANK_ROWS = 8,
  localparam int BANKS    = ROWS / BANK_ROWS,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int BIT_W    = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_i,
  output logic              pd_q_o,
  output logic              row_adv_o,
  output logic [ROW_W-1:0]  next_row_o,
  output logic [BIT_W-1:0]  bit_sel_o,
  output logic              rd_en_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic              frame_start_o
);
  localparam int SLOT_W = $clog2(ROW_CLKS);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(ROW_CLKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_FETCH = SLOT_W'(ROW_CLKS - 2);
  localparam logic [ROW_W-1:0]  ROW_LAST   = ROW_W'(ROWS - 1);

  logic              pd_q;
  logic [ROW_W-1:0]  row_q;
  logic [SLOT_W-1:0] slot_q;
  logic              fs_q;
  logic [ROW_W-1:0]  next_row;
  logic              fetch_slot;
  logic              row_adv;

  assign next_row   = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
  assign fetch_slot = !pd_q && (slot_q == SLOT_FETCH);
  assign row_adv    = !pd_q && (slot_q == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) pd_q <= 1'b1;
    else     pd_q <= pd_i;
  end

  always_ff @(posedge clk) begin
    if (rst || pd_q) begin
      row_q  <= ROW_LAST;
      slot_q <= SLOT_FETCH;
      fs_q   <= 1'b0;
    end else if (row_adv) begin
      row_q  <= next_row;
      slot_q <= '0;
      fs_q   <= (next_row == '0);
    end else begin
      slot_q <= slot_q + 1'b1;
      fs_q   <= 1'b0;
    end
  end

  assign pd_q_o        = pd_q;
  assign row_adv_o     = row_adv;
  assign next_row_o    = next_row;
  assign bit_sel_o     = BIT_W'(bit_of(int'(next_row), BANK_ROWS));
  assign rd_en_o       = fetch_slot;
  assign rd_bank_o     = BANK_W'(bank_of(int'(next_row), BANK_ROWS));
  assign frame_start_o = fs_q && !pd_q;

  // R9: one clock of power-down leaves the counters parked before row 0
  a_r9_parked: assert property (@(posedge clk) disable iff (rst)
    pd_q |=> (slot_q == SLOT_FETCH && row_q == ROW_LAST));

  // R5: a fetch is always followed by a row boundary unless power-down intervenes
  a_r5_fetch_leads_boundary: assert property (@(posedge clk) disable iff (rst)
    fetch_slot |=> (row_adv || pd_q));

endmodule

// File: rtl/col_assembler.sv
module col_assembler
  import scan_pkg::*;
#(
  parameter int COLS      = 84,
  parameter int BANK_ROWS = 8,
  localparam int BIT_W    = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pd_q_i,
  input  logic                      row_adv_i,
  input  logic [BIT_W-1:0]          bit_sel_i,
  input  logic [1:0]                mode_i,
  input  logic [COLS*BANK_ROWS-1:0] rd_data_i,
  output logic [COLS-1:0]           col_o
);
  disp_mode_e      mode_e;
  logic [COLS-1:0] col_next;
  logic [COLS-1:0] col_q;

  assign mode_e = disp_mode_e'(mode_i);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [BANK_ROWS-1:0] byte_c;
    assign byte_c      = rd_data_i[c*BANK_ROWS +: BANK_ROWS];
    assign col_next[c] = pixel_for_mode(mode_e, byte_c[bit_sel_i]);
  end

  always_ff @(posedge clk) begin
    if (rst || pd_q_i)  col_q <= '0;
    else if (row_adv_i) col_q <= col_next;
  end

  assign col_o = pd_q_i ? '0 : col_q;

  // R8: column pattern only moves at a row boundary or on power-down
  a_r8_cols_hold: assert property (@(posedge clk) disable iff (rst)
    (!row_adv_i && !pd_q_i) |=> $stable(col_q));

endmodule

// File: rtl/row_driver.sv
module row_driver #(
  parameter int ROWS   = 48,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_q_i,
  input  logic             row_adv_i,
  input  logic [ROW_W-1:0] next_row_i,
  output logic [ROWS-1:0]  row_sel_o
);
  logic [ROWS-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst || pd_q_i)  row_q <= '0;
    else if (row_adv_i) row_q <= ROWS'(1) << next_row_i;
  end

  assign row_sel_o = pd_q_i ? '0 : row_q;

  // R2: never more than one row selected
  a_r2_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel_o));

endmodule

// File: rtl/matrix_row_scanner.sv
module matrix_row_scanner #(
  parameter int ROWS      = 48,
  parameter int COLS      = 84,
  parameter int BANK_ROWS = 8,
  parameter int ROW_CLKS  = 10,
  localparam int BANKS    = ROWS / BANK_ROWS,
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pd_i,
  input  logic [1:0]                mode_i,
  input  logic [COLS*BANK_ROWS-1:0] rd_data_i,
  output logic                      rd_en_o,
  output logic [BANK_W-1:0]         rd_bank_o,
  output logic [ROWS-1:0]           row_sel_o,
  output logic [COLS-1:0]           col_o,
  output logic                      frame_start_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int BIT_W = (BANK_ROWS > 1) ? $clog2(BANK_ROWS) : 1;

  logic             pd_q;
  logic             row_adv;
  logic [ROW_W-1:0] next_row;
  logic [BIT_W-1:0] bit_sel;

  scan_timebase #(.ROWS(ROWS), .ROW_CLKS(ROW_CLKS), .BANK_ROWS(BANK_ROWS)) u_tb (
    .clk          (clk),
    .rst          (rst),
    .pd_i         (pd_i),
    .pd_q_o       (pd_q),
    .row_adv_o    (row_adv),
    .next_row_o   (next_row),
    .bit_sel_o    (bit_sel),
    .rd_en_o      (rd_en_o),
    .rd_bank_o    (rd_bank_o),
    .frame_start_o(frame_start_o)
  );

  col_assembler #(.COLS(COLS), .BANK_ROWS(BANK_ROWS)) u_col (
    .clk      (clk),
    .rst      (rst),
    .pd_q_i   (pd_q),
    .row_adv_i(row_adv),
    .bit_sel_i(bit_sel),
    .mode_i   (mode_i),
    .rd_data_i(rd_data_i),
    .col_o    (col_o)
  );

  row_driver #(.ROWS(ROWS)) u_row (
    .clk       (clk),
    .rst       (rst),
    .pd_q_i    (pd_q),
    .row_adv_i (row_adv),
    .next_row_i(next_row),
    .row_sel_o (row_sel_o)
  );

  // R4: the frame marker coincides with row 0 being selected
  a_r4_frame_on_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> row_sel_o[0]);

endmodule

// File: tb/tb_matrix_row_scanner.sv
module tb_matrix_row_scanner;
  localparam int ROWS = 48, COLS = 84, BR = 8, RC = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst, pd;
  logic [1:0]          mode;
  logic [COLS*BR-1:0]  rd_data;
  logic                rd_en, fs;
  logic [2:0]          rd_bank;
  logic [ROWS-1:0]     row_sel;
  logic [COLS-1:0]     cols;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  matrix_row_scanner dut (
    .clk(clk), .rst(rst), .pd_i(pd), .mode_i(mode), .rd_data_i(rd_data),
    .rd_en_o(rd_en), .rd_bank_o(rd_bank), .row_sel_o(row_sel),
    .col_o(cols), .frame_start_o(fs)
  );

  function automatic logic [7:0] byte_at(int b, int c);
    return 8'((b * 53 + c * 29 + 7) % 256);
  endfunction

  function automatic logic [COLS*BR-1:0] bank_word(int b);
    logic [COLS*BR-1:0] w;
    for (int c = 0; c < COLS; c++) w[c*8 +: 8] = byte_at(b, c);
    return w;
  endfunction

  function automatic logic [COLS-1:0] exp_cols(int r, logic [1:0] m);
    logic [COLS-1:0] v;
    logic [7:0] by;
    for (int c = 0; c < COLS; c++) begin
      by = byte_at(r / 8, c);
      case (m)
        2'b00:   v[c] = 1'b0;
        2'b10:   v[c] = by[r % 8];
        2'b01:   v[c] = 1'b1;
        default: v[c] = ~by[r % 8];
      endcase
    end
    return v;
  endfunction

  function automatic logic [ROWS-1:0] exp_row(int r);
    logic [ROWS-1:0] v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  // memory model: one-cycle read latency
  initial rd_data = '0;
  always @(posedge clk) if (rd_en) rd_data <= bank_word(int'(rd_bank));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_scan();
    pd = 1'b0;
    step();
    chk(rd_en == 1'b1 && rd_bank == 3'd0, "R10 fetch row0 after release", {rd_en, rd_bank}, {1'b1, 3'd0});
    step();
    chk(row_sel == '0 && fs == 1'b0, "R10 no row before boundary", row_sel, 0);
    step();
    chk(fs == 1'b1 && row_sel == exp_row(0), "R10 row0 begins", {fs, row_sel}, {1'b1, exp_row(0)});
  endtask

  task automatic sweep_frame(input logic [1:0] m, input string tag);
    for (int r = 0; r < ROWS; r++) begin
      chk(row_sel == exp_row(r), "R2 row select", row_sel, exp_row(r));
      chk(cols == exp_cols(r, m), tag, cols, exp_cols(r, m));
      chk(fs == (r == 0), "R4 frame marker", fs, (r == 0));
      for (int k = 1; k < RC; k++) begin
        step();
        if (k == 1) chk(fs == 1'b0, "R4 marker one clock", fs, 0);
        if (k == 8) chk(rd_en == 1'b1 && rd_bank == 3'(((r + 1) % ROWS) / 8),
                        "R5 fetch next bank", {rd_en, rd_bank}, {1'b1, 3'(((r + 1) % ROWS) / 8)});
        if (k == 9) begin
          chk(rd_en == 1'b0, "R5 single fetch", rd_en, 0);
          chk(row_sel == exp_row(r) && cols == exp_cols(r, m), "R3 row held 10 clocks",
              row_sel, exp_row(r));
        end
      end
      step();
    end
    chk(fs == 1'b1 && row_sel == exp_row(0), "R3 frame of 480 clocks", {fs, row_sel}, {1'b1, exp_row(0)});
  endtask

  initial begin
    logic [1:0] seq [4];
    logic [1:0] prev;
    int r;
    int bad;
    seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10;
    rst = 1'b1; pd = 1'b1; mode = 2'b00;
    repeat (4) step();
    chk(row_sel == '0 && cols == '0 && rd_en == 1'b0 && fs == 1'b0, "R1 reset state",
        {rd_en, fs, row_sel}, 0);
    rst = 1'b0;
    repeat (3) step();
    chk(row_sel == '0 && cols == '0 && rd_en == 1'b0 && fs == 1'b0, "R1 idle while powered down",
        {rd_en, fs, row_sel}, 0);

    mode = 2'b10;
    start_scan();
    sweep_frame(2'b10, "R6 normal bit slice");

    // mode changes mid-row, effect at next boundary
    r = 0;
    prev = 2'b10;
    for (int i = 0; i < 4; i++) begin
      for (int k = 1; k < RC; k++) begin
        step();
        if (k == 3) mode = seq[i];
        if (k == 9) chk(cols == exp_cols(r, prev), "R8 mode waits for boundary", cols, exp_cols(r, prev));
      end
      step();
      r++;
      chk(cols == exp_cols(r, seq[i]), "R7 mode applied", cols, exp_cols(r, seq[i]));
      prev = seq[i];
    end

    // power-down in the middle of a row
    repeat (4) step();
    pd = 1'b1;
    step();
    chk(row_sel == '0 && cols == '0 && fs == 1'b0, "R9 outputs off", {fs, row_sel}, 0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (rd_en || row_sel != '0 || cols != '0) bad++;
    end
    chk(bad == 0, "R9 scan stopped", bad, 0);

    mode = 2'b11;
    start_scan();
    sweep_frame(2'b11, "R7 inverse frame");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule